// File: doc/BRIEF.md
# DMA Burst Fragmenter with Bus Yield

This block turns one transfer request into a stream of bounded bus bursts. A request names an operation (copy or fill), a source address, a destination address, a byte length and a fill value. For a copy the block issues read bursts over the source range on a read command channel and write bursts over the destination range on a write command channel; the two channels run independently and each has its own valid/ready handshake. For a fill only write bursts are issued, and each carries the fill value.

Each direction has its own largest burst size and its own limit on how many bursts may be accepted back to back. When a direction reaches its limit it drops its command valid for one cycle, giving up the bus, and then starts a fresh run. All four settings are captured when the request is accepted. A single-cycle done pulse marks the end of each request, including requests of length zero, which issue no bursts.

Top module: `burst_splitter`

## Requirements
- R1: After reset, req_ready is 1, both command valids are 0 and done is 0.
- R2: Bursts of one direction cover the range in address order: the first starts at the base address, each next address is the previous address plus the previous length (modulo the address width), and each length is the smaller of the bytes still left and the largest burst size, so only the last burst may be short and the lengths sum to the request length.
- R3: Read bursts use cfg_rd_max_bytes and write bursts use cfg_wr_max_bytes; a largest burst size of 0 acts as 1.
- R4: A command valid is high exactly when its direction has bytes left and is not yielding; after the handshake that completes L consecutive accepted bursts in a direction (L from that direction's run limit, 0 acting as 1), that valid is low for exactly the next cycle, and the count starts again from zero after the gap or when a request begins.
- R5: While a command valid is high and its ready is low, valid, address and length stay unchanged.
- R6: req_op 0 is copy and issues both read and write bursts with wr_cmd_fill 0; req_op 1 is fill and issues write bursts only, with wr_cmd_fill 1 and wr_cmd_data equal to the request fill value.
- R7: An accepted request with length 0 issues no burst and raises done for one cycle in the cycle right after acceptance.
- R8: For a nonzero length, done is high for one cycle, in the second cycle after the cycle of the last burst handshake of the request, and req_ready returns to 1 in that same cycle.
- R9: req_ready is 0 from the edge that accepts a nonzero-length request until done; req_valid while req_ready is 0 has no effect.
- R10: Burst sizes and run limits are sampled at acceptance; changing the cfg inputs during a request does not alter its bursts or gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_rd_max_bytes | input | BURST_W | Largest read burst in bytes |
| cfg_wr_max_bytes | input | BURST_W | Largest write burst in bytes |
| cfg_rd_run_limit | input | RUN_W | Consecutive read bursts before a yield |
| cfg_wr_run_limit | input | RUN_W | Consecutive write bursts before a yield |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_op | input | 1 | 0 copy, 1 fill |
| req_src | input | ADDR_W | Source base address |
| req_dst | input | ADDR_W | Destination base address |
| req_len | input | LEN_W | Request length in bytes |
| req_fill | input | DATA_W | Fill value |
| rd_cmd_valid | output | 1 | Read burst command valid |
| rd_cmd_ready | input | 1 | Read burst command taken |
| rd_cmd_addr | output | ADDR_W | Read burst address |
| rd_cmd_len | output | BURST_W | Read burst length in bytes |
| wr_cmd_valid | output | 1 | Write burst command valid |
| wr_cmd_ready | input | 1 | Write burst command taken |
| wr_cmd_addr | output | ADDR_W | Write burst address |
| wr_cmd_len | output | BURST_W | Write burst length in bytes |
| wr_cmd_fill | output | 1 | Write burst carries the fill value |
| wr_cmd_data | output | DATA_W | Fill value for the write burst |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
Every command output settles one edge after the handshake or acceptance that moves it, a yield gap falls in the cycle right after the handshake that completes a run, done follows one edge after acceptance for an empty request and two edges after the final handshake otherwise, and req_ready falls one edge after acceptance. The bench keeps a cycle model built from these rules, drives all inputs on the falling edge and compares every output at the next falling edge, so each check looks at the cycle in which its result is due. It sweeps lengths, burst sizes, run limits and both operations, with ready patterns that stall, scrambled cfg inputs and stray req_valid pulses while busy.

// File: rtl/bsplit_pkg.sv
package bsplit_pkg;
    typedef enum logic {
        OP_COPY = 1'b0,
        OP_FILL = 1'b1
    } op_e;
endpackage

// File: rtl/bsplit_yield.sv
module bsplit_yield #(
    parameter int RUN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             fire_i,
    input  logic [RUN_W-1:0] limit_i,
    output logic             yield_o
);
    localparam int CNT_W = RUN_W + 1;

    typedef struct packed {
        logic [RUN_W-1:0] cnt;
        logic             yld;
    } yst_t;

    yst_t yst_d, yst_q;
    logic [CNT_W-1:0] next_cnt;

    always_comb begin
        yst_d    = yst_q;
        yst_d.yld = 1'b0;
        next_cnt = {1'b0, yst_q.cnt} + CNT_W'(1);
        if (fire_i) begin
            if (next_cnt >= {1'b0, limit_i}) begin
                yst_d.yld = 1'b1;
                yst_d.cnt = '0;
            end else begin
                yst_d.cnt = RUN_W'(next_cnt);
            end
        end else if (!active_i || yst_q.yld) begin
            yst_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            yst_q <= '0;
        end else begin
            yst_q <= yst_d;
        end
    end

    assign yield_o = yst_q.yld;

    // the running count never reaches the limit it is compared against
    assert_run_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (yst_q.cnt == '0) || (yst_q.cnt < limit_i));

    // a gap lasts a single cycle
    assert_gap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        yst_q.yld |=> !yst_q.yld);
endmodule

// File: rtl/bsplit_lane.sv
module bsplit_lane #(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int BURST_W = 11,
    parameter int RUN_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [ADDR_W-1:0]  base_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic [BURST_W-1:0] max_i,
    input  logic [RUN_W-1:0]   limit_i,
    output logic               cmd_valid_o,
    input  logic               cmd_ready_i,
    output logic [ADDR_W-1:0]  cmd_addr_o,
    output logic [BURST_W-1:0] cmd_len_o,
    output logic               busy_o
);
    localparam int CMP_W = (LEN_W > BURST_W) ? LEN_W : BURST_W;

    typedef struct packed {
        logic [ADDR_W-1:0]  addr;
        logic [LEN_W-1:0]   remain;
        logic [BURST_W-1:0] maxb;
        logic [RUN_W-1:0]   lim;
    } lst_t;

    lst_t lst_d, lst_q;
    logic [BURST_W-1:0] eff_max;
    logic [CMP_W-1:0]   cut;
    logic [BURST_W-1:0] blen;
    logic               live;
    logic               yield_w;
    logic               fire;

    always_comb begin
        eff_max = (lst_q.maxb == '0) ? BURST_W'(1) : lst_q.maxb;
        cut     = (CMP_W'(lst_q.remain) < CMP_W'(eff_max)) ? CMP_W'(lst_q.remain)
                                                            : CMP_W'(eff_max);
        blen    = BURST_W'(cut);
        live    = (lst_q.remain != '0);
        fire    = live && !yield_w && cmd_ready_i;
        lst_d   = lst_q;
        if (start_i) begin
            lst_d.addr   = base_i;
            lst_d.remain = len_i;
            lst_d.maxb   = max_i;
            lst_d.lim    = limit_i;
        end else if (fire) begin
            lst_d.addr   = lst_q.addr + ADDR_W'(blen);
            lst_d.remain = lst_q.remain - LEN_W'(blen);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lst_q <= '0;
        end else begin
            lst_q <= lst_d;
        end
    end

    bsplit_yield #(.RUN_W(RUN_W)) u_yield (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (live),
        .fire_i   (fire),
        .limit_i  (lst_q.lim),
        .yield_o  (yield_w)
    );

    assign cmd_valid_o = live && !yield_w;
    assign cmd_addr_o  = lst_q.addr;
    assign cmd_len_o   = blen;
    assign busy_o      = live;

    // burst length is nonzero, within the size limit and within what is left
    assert_burst_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_len_o != '0) && (cmd_len_o <= eff_max) &&
                        (CMP_W'(cmd_len_o) <= CMP_W'(lst_q.remain)));

    // an offered command waits unchanged for its ready
    assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=>
            (cmd_valid_o && $stable(cmd_addr_o) && $stable(cmd_len_o)));

    // an accepted burst moves the window forward by its own length
    assert_addr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_ready_i) |=>
            (lst_q.addr == $past(cmd_addr_o) + ADDR_W'($past(cmd_len_o))) &&
            (lst_q.remain == $past(lst_q.remain) - LEN_W'($past(cmd_len_o))));
endmodule

// File: rtl/burst_splitter.sv
module burst_splitter
    import bsplit_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LEN_W   = 16,
    parameter int BURST_W = 11,
    parameter int RUN_W   = 5,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BURST_W-1:0] cfg_rd_max_bytes,
    input  logic [BURST_W-1:0] cfg_wr_max_bytes,
    input  logic [RUN_W-1:0]   cfg_rd_run_limit,
    input  logic [RUN_W-1:0]   cfg_wr_run_limit,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_op,
    input  logic [ADDR_W-1:0]  req_src,
    input  logic [ADDR_W-1:0]  req_dst,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [DATA_W-1:0]  req_fill,
    output logic               rd_cmd_valid,
    input  logic               rd_cmd_ready,
    output logic [ADDR_W-1:0]  rd_cmd_addr,
    output logic [BURST_W-1:0] rd_cmd_len,
    output logic               wr_cmd_valid,
    input  logic               wr_cmd_ready,
    output logic [ADDR_W-1:0]  wr_cmd_addr,
    output logic [BURST_W-1:0] wr_cmd_len,
    output logic               wr_cmd_fill,
    output logic [DATA_W-1:0]  wr_cmd_data,
    output logic               done
);
    typedef struct packed {
        logic              busy;
        logic              done;
        op_e               op;
        logic [DATA_W-1:0] fill;
    } tst_t;

    tst_t tst_d, tst_q;
    logic accept, nonzero, rd_start, wr_start;
    logic rd_busy, wr_busy;

    always_comb begin
        accept   = req_valid && !tst_q.busy;
        nonzero  = (req_len != '0);
        rd_start = accept && nonzero && (op_e'(req_op) == OP_COPY);
        wr_start = accept && nonzero;
        tst_d      = tst_q;
        tst_d.done = (accept && !nonzero) || (tst_q.busy && !rd_busy && !wr_busy);
        if (accept) begin
            tst_d.op   = op_e'(req_op);
            tst_d.fill = req_fill;
            tst_d.busy = nonzero;
        end else if (tst_q.busy && !rd_busy && !wr_busy) begin
            tst_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tst_q <= '{busy: 1'b0, done: 1'b0, op: OP_COPY, fill: '0};
        end else begin
            tst_q <= tst_d;
        end
    end

    bsplit_lane #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W), .RUN_W(RUN_W)
    ) u_rd_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (rd_start),
        .base_i      (req_src),
        .len_i       (req_len),
        .max_i       (cfg_rd_max_bytes),
        .limit_i     (cfg_rd_run_limit),
        .cmd_valid_o (rd_cmd_valid),
        .cmd_ready_i (rd_cmd_ready),
        .cmd_addr_o  (rd_cmd_addr),
        .cmd_len_o   (rd_cmd_len),
        .busy_o      (rd_busy)
    );

    bsplit_lane #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W), .RUN_W(RUN_W)
    ) u_wr_lane (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (wr_start),
        .base_i      (req_dst),
        .len_i       (req_len),
        .max_i       (cfg_wr_max_bytes),
        .limit_i     (cfg_wr_run_limit),
        .cmd_valid_o (wr_cmd_valid),
        .cmd_ready_i (wr_cmd_ready),
        .cmd_addr_o  (wr_cmd_addr),
        .cmd_len_o   (wr_cmd_len),
        .busy_o      (wr_busy)
    );

    assign req_ready   = !tst_q.busy;
    assign done        = tst_q.done;
    assign wr_cmd_fill = (tst_q.op == OP_FILL);
    assign wr_cmd_data = tst_q.fill;

    // a fill request never reaches the read channel
    assert_fill_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_q.busy && (tst_q.op == OP_FILL)) |-> !rd_cmd_valid);

    // the end pulse comes only once both channels are quiet
    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_cmd_valid && !wr_cmd_valid && req_ready));
endmodule

// File: tb/burst_splitter_tb_top.sv
module burst_splitter_tb_top;
    localparam int ADDR_W  = 12;
    localparam int LEN_W   = 6;
    localparam int BURST_W = 3;
    localparam int RUN_W   = 2;
    localparam int DATA_W  = 8;
    localparam int AMASK   = (1 << ADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [BURST_W-1:0] cfg_rd_max_bytes = '0, cfg_wr_max_bytes = '0;
    logic [RUN_W-1:0]   cfg_rd_run_limit = '0, cfg_wr_run_limit = '0;
    logic               req_valid = 1'b0, req_op = 1'b0;
    logic [ADDR_W-1:0]  req_src = '0, req_dst = '0;
    logic [LEN_W-1:0]   req_len = '0;
    logic [DATA_W-1:0]  req_fill = '0;
    logic               rd_cmd_ready = 1'b0, wr_cmd_ready = 1'b0;
    logic               req_ready, rd_cmd_valid, wr_cmd_valid, wr_cmd_fill, done;
    logic [ADDR_W-1:0]  rd_cmd_addr, wr_cmd_addr;
    logic [BURST_W-1:0] rd_cmd_len, wr_cmd_len;
    logic [DATA_W-1:0]  wr_cmd_data;

    burst_splitter #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_W(BURST_W), .RUN_W(RUN_W), .DATA_W(DATA_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_rd_max_bytes(cfg_rd_max_bytes), .cfg_wr_max_bytes(cfg_wr_max_bytes),
        .cfg_rd_run_limit(cfg_rd_run_limit), .cfg_wr_run_limit(cfg_wr_run_limit),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_dst(req_dst), .req_len(req_len), .req_fill(req_fill),
        .rd_cmd_valid(rd_cmd_valid), .rd_cmd_ready(rd_cmd_ready),
        .rd_cmd_addr(rd_cmd_addr), .rd_cmd_len(rd_cmd_len),
        .wr_cmd_valid(wr_cmd_valid), .wr_cmd_ready(wr_cmd_ready),
        .wr_cmd_addr(wr_cmd_addr), .wr_cmd_len(wr_cmd_len),
        .wr_cmd_fill(wr_cmd_fill), .wr_cmd_data(wr_cmd_data), .done(done)
    );

    int vectors = 0;
    int miscompares = 0;
    logic [15:0] lfsr = 16'hACE1;
    int ready_mode = 0;

    // cycle model of the requirements; index 0 read, 1 write
    bit m_busy = 0, m_done = 0, m_zero = 0, m_op = 0;
    int m_fill = 0;
    int m_rem[2], m_addr[2], m_max[2], m_lim[2], m_run[2];
    bit m_y[2], m_stall[2];

    task automatic chk(input string tag, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void step_lfsr();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endfunction

    function automatic int blen(input int l);
        int mx = (m_max[l] == 0) ? 1 : m_max[l];
        return (m_rem[l] < mx) ? m_rem[l] : mx;
    endfunction

    task automatic run_cycle(input bit rv, input bit op, input int src, input int dst,
                             input int len, input int fill, input int rmax, input int wmax,
                             input int rlim, input int wlim);
        bit v[2], rdy[2], fire[2], accept, idle;
        // compare this cycle's outputs with the model
        chk("R9", req_ready, !m_busy);
        chk(m_zero ? "R7" : "R8", done, m_done);
        for (int l = 0; l < 2; l++) v[l] = (m_rem[l] != 0) && !m_y[l];
        chk("R4 rd valid", rd_cmd_valid, v[0]);
        chk("R4 wr valid", wr_cmd_valid, v[1]);
        if (v[0]) begin
            chk(m_stall[0] ? "R5 rd addr" : "R2 rd addr", rd_cmd_addr, m_addr[0]);
            chk("R3/R10 rd len", rd_cmd_len, blen(0));
        end
        if (v[1]) begin
            chk(m_stall[1] ? "R5 wr addr" : "R2 wr addr", wr_cmd_addr, m_addr[1]);
            chk("R3/R10 wr len", wr_cmd_len, blen(1));
            chk("R6 fill flag", wr_cmd_fill, m_op);
            if (m_op) chk("R6 fill data", wr_cmd_data, m_fill);
        end
        // drive the next cycle's inputs
        step_lfsr();
        case (ready_mode)
            0: begin rdy[0] = 1'b1; rdy[1] = 1'b1; end
            1: begin rdy[0] = lfsr[0]; rdy[1] = lfsr[3]; end
            default: begin rdy[0] = lfsr[1] | lfsr[5]; rdy[1] = lfsr[2] | lfsr[7]; end
        endcase
        rd_cmd_ready = rdy[0];
        wr_cmd_ready = rdy[1];
        req_valid = rv;
        req_op    = op;
        req_src   = ADDR_W'(src);
        req_dst   = ADDR_W'(dst);
        req_len   = LEN_W'(len);
        req_fill  = DATA_W'(fill);
        cfg_rd_max_bytes = BURST_W'(rmax);
        cfg_wr_max_bytes = BURST_W'(wmax);
        cfg_rd_run_limit = RUN_W'(rlim);
        cfg_wr_run_limit = RUN_W'(wlim);
        // advance the model
        accept = rv && !m_busy;
        idle = (m_rem[0] == 0) && (m_rem[1] == 0);
        for (int l = 0; l < 2; l++) begin
            int b;
            fire[l] = v[l] && rdy[l];
            m_stall[l] = v[l] && !rdy[l];
            m_y[l] = 0;
            if (fire[l]) begin
                b = blen(l);
                m_addr[l] = (m_addr[l] + b) & AMASK;
                m_rem[l] -= b;
                if (m_run[l] + 1 >= m_lim[l]) begin
                    m_y[l] = 1;
                    m_run[l] = 0;
                end else begin
                    m_run[l]++;
                end
            end else if (m_rem[l] == 0) begin
                m_run[l] = 0;
            end
        end
        m_done = (accept && len == 0) || (m_busy && idle);
        m_zero = accept && len == 0;
        if (accept) begin
            m_op = op;
            m_fill = fill & ((1 << DATA_W) - 1);
            m_busy = (len != 0);
            if (len != 0) begin
                if (!op) begin
                    m_rem[0] = len; m_addr[0] = src & AMASK;
                    m_max[0] = rmax; m_lim[0] = rlim; m_run[0] = 0;
                end
                m_rem[1] = len; m_addr[1] = dst & AMASK;
                m_max[1] = wmax; m_lim[1] = wlim; m_run[1] = 0;
            end
        end else if (m_busy && idle) begin
            m_busy = 0;
        end
        @(negedge clk);
    endtask

    // busy cycle: stray request and scrambled settings must change nothing (R9, R10)
    task automatic noise_cycle();
        step_lfsr();
        run_cycle(lfsr[4], lfsr[6], int'(lfsr[11:0]), int'(lfsr[15:4]), int'(lfsr[5:0]),
                  int'(lfsr[7:0]), int'(lfsr[2:0]), int'(lfsr[5:3]),
                  int'(lfsr[9:8]), int'(lfsr[11:10]));
    endtask

    initial begin
        for (int l = 0; l < 2; l++) begin
            m_rem[l] = 0; m_addr[l] = 0; m_max[l] = 0; m_lim[l] = 0;
            m_run[l] = 0; m_y[l] = 0; m_stall[l] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_ready", req_ready, 1);
        chk("R1 rd valid", rd_cmd_valid, 0);
        chk("R1 wr valid", wr_cmd_valid, 0);
        chk("R1 done", done, 0);
        for (int op = 0; op < 2; op++)
            for (int len = 0; len < 24; len++)
                for (int wm = 0; wm < 8; wm++)
                    for (int lim = 0; lim < 4; lim++) begin
                        ready_mode = (len + wm) % 3;
                        while (m_busy) noise_cycle();
                        run_cycle(1'b1, op[0], (len * 37 + wm * 101) & AMASK,
                                  (AMASK - 15 + len * 3 + lim) & AMASK, len,
                                  len * 7 + wm, (wm * 5 + 3) % 8, wm, (lim + 2) % 4, lim);
                    end
        while (m_busy || m_done) noise_cycle();
        repeat (3) run_cycle(1'b0, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule